// File: doc/BRIEF.md
# Presettable BCD Decade Digit Counter

This block is one decimal digit of a synchronous counter. It holds a 4-bit state that advances through the 8421 codes 0 to 9 and then back to 0. Counting happens on a rising clock edge only while two count enables are both high. One enable is meant to be driven in parallel across all digits. The other ripples down a digit chain and also gates the terminal-count output, so several instances can be cascaded into a synchronous multi-digit counter.

A low load strobe copies a 4-bit data word into the state. A low reset clears the state. The parameter `RESET_SYNC` selects how the clear acts. With a value of 1, the clear takes effect on the next clock edge. With a value of 0, the clear is asynchronous and acts at once. The port is the same in both cases. If the state ever holds one of the six unused codes, counting returns it to the legal sequence within two counts.

Top module: `bcd_digit_counter`

## Requirements
- R1: With reset and load inactive and both enables high, each rising edge advances the state one step through 0,1,...,8,9, and 9 is followed by 0.
- R2: With reset and load inactive, if either enable is low the state holds across the edge.
- R3: When reset is inactive and `load_n` is low, the next edge places `din` into `q` for any enable values. Codes 10 to 15 are stored unchanged.
- R4: With `RESET_SYNC`=1, a low `rst_n` at a rising edge makes `q` zero after that edge, whatever the load and enable inputs are. Before that edge `q` is unaffected.
- R5: With `RESET_SYNC`=0, a low `rst_n` forces `q` to zero without waiting for a clock edge.
- R6: `tc` is high exactly when `cet` is high and `q` equals 9. It is never high for codes 10 to 15.
- R7: Counting from an unused code follows 10→11→6, 12→13→4 and 14→15→2, so the state is back in 0..9 after at most two counting edges.
- R8: `tc` follows `cet` combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; style chosen by `RESET_SYNC` |
| load_n | input | 1 | Active-low parallel load strobe |
| cep | input | 1 | Parallel count enable |
| cet | input | 1 | Trickle count enable; also gates `tc` |
| din | input | 4 | Parallel load data |
| q | output | 4 | Registered digit state |
| tc | output | 1 | Terminal count, high at state 9 with `cet` high |

## Verification
The embedded properties check every clocked step outside reset on every cycle. They cover the legal increment and the 9-to-0 wrap, the hold when an enable is low, the load of `din`, and the return from unused codes within two counts. The bench scenarios alone show the behaviour of reset itself. This covers the edge-timed clear and the immediate asynchronous clear, which are compared on two instances driven side by side. The bench also shows that `tc` follows `cet` between edges, and it steps through all sixteen control combinations to confirm their precedence.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t DIGIT_LAST = digit_t'(9);

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/bcd_mode_sel.sv
`timescale 1ns/1ps
module bcd_mode_sel
  import bcd_pkg::*;
(
  input  logic  rst_n,
  input  logic  load_n,
  input  logic  cep,
  input  logic  cet,
  output mode_e mode
);
  // fixed priority: clear, then load, then count, else hold
  always_comb begin
    if (!rst_n)            mode = MODE_CLEAR;
    else if (!load_n)      mode = MODE_LOAD;
    else if (cep && cet)   mode = MODE_COUNT;
    else                   mode = MODE_HOLD;
  end
endmodule

// File: rtl/bcd_step.sv
`timescale 1ns/1ps
module bcd_step
  import bcd_pkg::*;
(
  input  digit_t cur,
  output digit_t nxt
);
  logic [DIGIT_W:0] fold;

  // odd unused codes fold back to 17 - code (11->6, 13->4, 15->2)
  assign fold = (DIGIT_W+1)'(17) - {1'b0, cur};

  always_comb begin
    if (cur == DIGIT_LAST)      nxt = '0;
    else if (cur < DIGIT_LAST)  nxt = cur + digit_t'(1);
    else if (!cur[0])           nxt = cur + digit_t'(1);
    else                        nxt = fold[DIGIT_W-1:0];
  end
endmodule

// File: rtl/bcd_tc_dec.sv
`timescale 1ns/1ps
module bcd_tc_dec
  import bcd_pkg::*;
(
  input  digit_t cur,
  input  logic   cet,
  output logic   tc
);
  assign tc = cet && (cur == DIGIT_LAST);
endmodule

// File: rtl/bcd_digit_counter.sv
`timescale 1ns/1ps
module bcd_digit_counter
  import bcd_pkg::*;
#(
  parameter bit RESET_SYNC = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         cep,
  input  logic         cet,
  input  logic [3:0]   din,
  output logic [3:0]   q,
  output logic         tc
);
  mode_e  mode;
  digit_t state_q;
  digit_t step_d;
  digit_t next_d;

  bcd_mode_sel u_mode (
    .rst_n (rst_n),
    .load_n(load_n),
    .cep   (cep),
    .cet   (cet),
    .mode  (mode)
  );

  bcd_step u_step (
    .cur(state_q),
    .nxt(step_d)
  );

  bcd_tc_dec u_tc (
    .cur(state_q),
    .cet(cet),
    .tc (tc)
  );

  always_comb begin
    unique case (mode)
      MODE_CLEAR: next_d = '0;
      MODE_LOAD:  next_d = din;
      MODE_COUNT: next_d = step_d;
      default:    next_d = state_q;
    endcase
  end

  generate
    if (RESET_SYNC) begin : g_sync_clr
      always_ff @(posedge clk) state_q <= next_d;
    end else begin : g_async_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= next_d;
      end
    end
  endgenerate

  assign q = state_q;

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cep && cet && q < 4'd9) |=> (q == $past(q) + 4'd1));

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cep && cet && q == 4'd9) |=> (q == 4'd0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(cep && cet)) |=> $stable(q));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n) |=> (q == $past(din)));

  // R7
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cep && cet && q > 4'd9) |=>
      (q <= 4'd9 || $past(q) == 4'd10 || $past(q) == 4'd12 || $past(q) == 4'd14));

  // R6
  tc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (cet && q <= 4'd9));
endmodule

// File: tb/bcd_digit_counter_bench.sv
`timescale 1ns/1ps
module bcd_digit_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic       cep = 1'b0;
  logic       cet = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] q_s, q_a;
  logic       tc_s, tc_a;

  int checks = 0;
  int errors = 0;
  logic [3:0] model_q = 4'd0;
  logic [3:0] exp_q[$];
  string      exp_tag[$];

  always #2.5 clk = ~clk;

  bcd_digit_counter #(.RESET_SYNC(1'b1)) u_bcd_digit_counter (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cep(cep), .cet(cet),
    .din(din), .q(q_s), .tc(tc_s));

  bcd_digit_counter #(.RESET_SYNC(1'b0)) u_bcd_digit_counter_async (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cep(cep), .cet(cet),
    .din(din), .q(q_a), .tc(tc_a));

  function automatic logic [3:0] ref_step(input logic [3:0] c);
    case (c)
      4'd9:  return 4'd0;
      4'd10: return 4'd11;
      4'd11: return 4'd6;
      4'd12: return 4'd13;
      4'd13: return 4'd4;
      4'd14: return 4'd15;
      4'd15: return 4'd2;
      default: return c + 4'd1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: apply controls for one edge and queue the predicted state
  task automatic drive(input logic r, input logic l, input logic p, input logic t,
                       input logic [3:0] d, input string tag);
    @(negedge clk);
    rst_n = r; load_n = l; cep = p; cet = t; din = d;
    if (!r)          model_q = 4'd0;
    else if (!l)     model_q = d;
    else if (p && t) model_q = ref_step(model_q);
    exp_q.push_back(model_q);
    exp_tag.push_back(tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string      g;
      e = exp_q.pop_front();
      g = exp_tag.pop_front();
      check({g, " q sync"},  q_s, e);
      check({g, " q async"}, q_a, e);
      check({g, " tc R6"},   {3'b0, tc_s}, {3'b0, (e == 4'd9) && cet});
      check({g, " tc async R6"}, {3'b0, tc_a}, {3'b0, (e == 4'd9) && cet});
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired R1 actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // reset state R4/R5
    drive(0, 1, 1, 1, 4'd0, "R4 reset");
    drive(0, 0, 1, 1, 4'd5, "R4 reset over load");
    // R1 full count with wrap
    for (int i = 0; i < 12; i++) drive(1, 1, 1, 1, 4'd0, "R1 count");
    // R2 hold with each enable low
    drive(1, 1, 0, 1, 4'd0, "R2 hold cep low");
    drive(1, 1, 1, 0, 4'd0, "R2 hold cet low");
    drive(1, 1, 0, 0, 4'd0, "R2 hold both low");
    // R3 load ignores enables
    drive(1, 0, 0, 0, 4'd8, "R3 load enables off");
    drive(1, 0, 1, 1, 4'd3, "R3 load enables on");
    // R7 every unused code, loaded unchanged, then two counts
    for (int c = 10; c < 16; c++) begin
      drive(1, 0, 0, 1, 4'(c), "R3 load unused code");
      drive(1, 1, 1, 1, 4'd0, "R7 recover step1");
      drive(1, 1, 1, 1, 4'd0, "R7 recover step2");
    end
    // precedence over all control combinations, from state 7, data 2
    for (int m = 0; m < 16; m++) begin
      drive(1, 0, 0, 0, 4'd7, "R3 preset");
      drive(m[3], m[2], m[1], m[0], 4'd2, "R2 R4 precedence");
    end
    // R6/R8 tc follows cet between edges at state 9
    drive(1, 0, 0, 1, 4'd9, "R6 load nine");
    @(posedge clk); #1.5;
    check("R6 tc at nine", {3'b0, tc_s}, 4'd1);
    @(negedge clk);
    cet = 1'b0; load_n = 1'b1; #0.5;
    check("R8 tc drops with cet", {3'b0, tc_s}, 4'd0);
    cet = 1'b1; #0.5;
    check("R8 tc rises with cet", {3'b0, tc_s}, 4'd1);
    exp_q.push_back(model_q); exp_tag.push_back("R6 hold nine");
    cep = 1'b0;
    // R5 async clear before edge; R4 sync waits for edge
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R5 async clear immediate", q_a, 4'd0);
    check("R4 sync clear waits", q_s, 4'd9);
    model_q = 4'd0;
    exp_q.push_back(4'd0); exp_tag.push_back("R4 clear at edge");
    drive(1, 1, 1, 1, 4'd0, "R1 count after clear");
    @(posedge clk); #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule